// File: doc/BRIEF.md
# Re-Reference Interval Victim Selector for a Skewed-Associative Cache

This block keeps the replacement state of a skewed-associative cache. Each way owns a separate array of 2-bit re-reference prediction values (RRPVs). Each array is addressed by that way's own hashed set index, so the replacement candidates for one access can come from different sets. Tag comparison and data movement stay outside the block. The surrounding cache controller reports each lookup as a hit, which names the way that hit, or as a miss. It supplies one index per way on a packed bus and signals a fill when a new block lands in a way.

On a hit, the RRPV of the block that hit is cleared so that the block is kept. On a miss, the block reads one candidate per way. It ages all candidates in a single step until the largest one reaches the maximum value 3, writes the aged values back, and reports the victim way. A later fill strobe loads the inserted block with RRPV 2. Miss handling occupies the unit for two cycles, and `ready` is low during that time.

Top module: `rrip_victim_sel`

## Requirements
- R1: After reset, `ready` is 1, `victim_valid` is 0 and every RRPV in every way is 3. The first miss after reset therefore selects way 0.
- R2: A hit accepted while `ready` is 1 sets the RRPV of entry (`req_way`, index of that way) to 0.
- R3: A fill accepted while `ready` is 1 sets the RRPV of entry (`fill_way`, index of that way) to 2.
- R4: On a miss, the victim is the lowest-numbered way whose candidate RRPV equals the largest candidate RRPV. This is the first candidate to reach 3 under repeated aging.
- R5: On a miss, every candidate is written back increased by (3 minus the largest candidate value), so the victim's entry holds 3 afterwards.
- R6: A miss accepted at clock edge E0 drives `ready` low from E0 to edge E2. `victim_valid` is 1 with `victim_way` valid for exactly the cycle between E1 and E2. `ready` is 1 again after E2.
- R7: Requests and fills presented while `ready` is 0 are ignored and change no RRPV.
- R8: A hit and a fill to the same entry in the same cycle leave that entry at 2, because the fill wins. A hit and a fill to different entries are both applied.
- R9: Way w reads and writes only at the index in bits [w*SET_BITS +: SET_BITS] of `set_idx`. For a miss, these are the index bits sampled at E0.
- R10: A hit changes no entry other than the one it names, and `ready` stays 1 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup result present |
| req_hit | input | 1 | 1 = hit, 0 = miss |
| req_way | input | WAY_W | Way that hit |
| set_idx | input | WAYS*SET_BITS | Per-way hashed set indices, way w at bits [w*SET_BITS +: SET_BITS] |
| fill_valid | input | 1 | New block inserted |
| fill_way | input | WAY_W | Way receiving the new block |
| ready | output | 1 | Unit idle and accepting requests and fills |
| victim_valid | output | 1 | Victim report valid, for one cycle |
| victim_way | output | WAY_W | Selected victim way |

## Verification
The RRPV arrays cannot be seen from outside, so a corrupted entry shows up only as a wrong `victim_way`. It appears on the first miss whose candidate set includes that entry, two cycles after that miss is accepted. An aging error stays hidden until a later miss touches the same entries, so the bench keeps its own model of every entry. It uses small index ranges so that entries are revisited often. Faults in the busy handshake show up at once, as `ready` or `victim_valid` in the wrong cycle.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  localparam int unsigned RRPV_W = 2;
  typedef logic [RRPV_W-1:0] rrpv_t;
  localparam rrpv_t RRPV_MAX = '1;
  localparam rrpv_t RRPV_INS = RRPV_MAX - rrpv_t'(1);
  localparam rrpv_t RRPV_HIT = '0;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} ctl_state_e;
endpackage

// File: rtl/rrip_way_array.sv
module rrip_way_array
  import rrip_pkg::*;
#(
  parameter int unsigned SET_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_idx,
  output rrpv_t               rd_val,
  input  logic                upd_en,
  input  logic [SET_BITS-1:0] upd_idx,
  input  rrpv_t               upd_val,
  input  logic                fill_en,
  input  logic [SET_BITS-1:0] fill_idx,
  input  rrpv_t               fill_val
);
  localparam int unsigned SETS = 1 << SET_BITS;

  rrpv_t mem_q [SETS];
  rrpv_t mem_d [SETS];

  // fill port applied last: it wins on a shared entry
  always_comb begin
    mem_d = mem_q;
    if (upd_en)  mem_d[upd_idx]  = upd_val;
    if (fill_en) mem_d[fill_idx] = fill_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) mem_q[i] <= RRPV_MAX;
    end else begin
      mem_q <= mem_d;
    end
  end

  assign rd_val = mem_q[rd_idx];
endmodule

// File: rtl/rrip_age_unit.sv
module rrip_age_unit
  import rrip_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = $clog2(WAYS)
) (
  input  rrpv_t [WAYS-1:0] cand,
  output rrpv_t [WAYS-1:0] aged,
  output logic [WAY_W-1:0] victim
);
  rrpv_t peak;
  rrpv_t lift;
  logic  found;

  always_comb begin
    peak = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cand[w] > peak) peak = cand[w];
    end
    lift   = RRPV_MAX - peak;
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      aged[w] = cand[w] + lift;
      if (!found && (cand[w] == peak)) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rrip_ctrl.sv
module rrip_ctrl
  import rrip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_hit,
  input  logic fill_valid,
  output logic ready,
  output logic hit_acc,
  output logic miss_acc,
  output logic fill_acc,
  output logic cand_en,
  output logic wb_en
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid && !req_hit) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ready    = (state_q == ST_IDLE);
  assign hit_acc  = ready && req_valid && req_hit;
  assign miss_acc = ready && req_valid && !req_hit;
  assign fill_acc = ready && fill_valid;
  assign cand_en  = (state_q == ST_READ);
  assign wb_en    = (state_q == ST_WRITE);
endmodule

// File: rtl/rrip_victim_sel.sv
module rrip_victim_sel
  import rrip_pkg::*;
#(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned SET_BITS = 4,
  parameter int unsigned WAY_W    = $clog2(WAYS),
  parameter int unsigned IDX_W    = WAYS * SET_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_hit,
  input  logic [WAY_W-1:0] req_way,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             fill_valid,
  input  logic [WAY_W-1:0] fill_way,
  output logic             ready,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  logic hit_acc, miss_acc, fill_acc, cand_en, wb_en;

  logic  [WAYS-1:0][SET_BITS-1:0] idx_in;
  logic  [WAYS-1:0][SET_BITS-1:0] idx_q, idx_d;
  rrpv_t [WAYS-1:0]               rd_val;
  rrpv_t [WAYS-1:0]               cand_q, cand_d;
  rrpv_t [WAYS-1:0]               aged;

  rrip_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_hit    (req_hit),
    .fill_valid (fill_valid),
    .ready      (ready),
    .hit_acc    (hit_acc),
    .miss_acc   (miss_acc),
    .fill_acc   (fill_acc),
    .cand_en    (cand_en),
    .wb_en      (wb_en)
  );

  // index capture on miss acceptance, candidate capture in read cycle
  always_comb begin
    idx_d  = idx_q;
    cand_d = cand_q;
    if (miss_acc) idx_d  = idx_in;
    if (cand_en)  cand_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cand_q <= '0;
    end else begin
      idx_q  <= idx_d;
      cand_q <= cand_d;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic                upd_en;
    logic [SET_BITS-1:0] upd_idx;
    rrpv_t               upd_val;
    logic                fill_en;

    assign idx_in[w] = set_idx[w*SET_BITS +: SET_BITS];
    assign upd_en    = (hit_acc && (req_way == WAY_W'(w))) || wb_en;
    assign upd_idx   = wb_en ? idx_q[w] : idx_in[w];
    assign upd_val   = wb_en ? aged[w] : RRPV_HIT;
    assign fill_en   = fill_acc && (fill_way == WAY_W'(w));

    rrip_way_array #(.SET_BITS(SET_BITS)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (idx_q[w]),
      .rd_val   (rd_val[w]),
      .upd_en   (upd_en),
      .upd_idx  (upd_idx),
      .upd_val  (upd_val),
      .fill_en  (fill_en),
      .fill_idx (idx_in[w]),
      .fill_val (RRPV_INS)
    );
  end

  rrip_age_unit #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
    .cand   (cand_q),
    .aged   (aged),
    .victim (victim_way)
  );

  assign victim_valid = wb_en;
endmodule

// File: rtl/rrip_victim_sel_chk.sv
module rrip_victim_sel_chk #(
  parameter int unsigned WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_hit,
  input logic             ready,
  input logic             victim_valid,
  input logic [WAY_W-1:0] victim_way
);
  // R6
  miss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && !req_hit) |=> (!ready && !victim_valid));

  // R6
  miss_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && !req_hit) |=> ##1 (victim_valid && !ready));

  // R6
  report_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> (ready && !victim_valid));

  // R10
  hit_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && req_hit) |=> ready);

  // R7
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !victim_valid) |=> (victim_valid && $stable(ready)));

  // R4
  victim_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> !$isunknown(victim_way));
endmodule

bind rrip_victim_sel rrip_victim_sel_chk #(.WAY_W(WAY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_hit      (req_hit),
  .ready        (ready),
  .victim_valid (victim_valid),
  .victim_way   (victim_way)
);

// File: tb/tb_rrip_victim_sel.sv
module tb_rrip_victim_sel;
  localparam int WAYS     = 4;
  localparam int SET_BITS = 4;
  localparam int SETS     = 1 << SET_BITS;
  localparam int WAY_W    = $clog2(WAYS);
  localparam int IDX_W    = WAYS * SET_BITS;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_hit, fill_valid;
  logic [WAY_W-1:0] req_way, fill_way;
  logic [IDX_W-1:0] set_idx;
  logic             ready, victim_valid;
  logic [WAY_W-1:0] victim_way;

  int model [WAYS][SETS];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rrip_victim_sel #(.WAYS(WAYS), .SET_BITS(SET_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_way(req_way), .set_idx(set_idx), .fill_valid(fill_valid),
    .fill_way(fill_way), .ready(ready), .victim_valid(victim_valid),
    .victim_way(victim_way)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int way_idx(logic [IDX_W-1:0] ix, int w);
    return int'(ix[w*SET_BITS +: SET_BITS]);
  endfunction

  function automatic logic [IDX_W-1:0] pack_idx(int a, int b, int c, int d);
    return {SET_BITS'(d), SET_BITS'(c), SET_BITS'(b), SET_BITS'(a)};
  endfunction

  // expected victim: lowest way holding the largest candidate
  function automatic int exp_victim(logic [IDX_W-1:0] ix);
    int peak = 0;
    int vic = 0;
    for (int w = 0; w < WAYS; w++)
      if (model[w][way_idx(ix, w)] > peak) peak = model[w][way_idx(ix, w)];
    for (int w = WAYS - 1; w >= 0; w--)
      if (model[w][way_idx(ix, w)] == peak) vic = w;
    return vic;
  endfunction

  function automatic void age_model(logic [IDX_W-1:0] ix);
    int peak = 0;
    for (int w = 0; w < WAYS; w++)
      if (model[w][way_idx(ix, w)] > peak) peak = model[w][way_idx(ix, w)];
    for (int w = 0; w < WAYS; w++)
      model[w][way_idx(ix, w)] += 3 - peak;
  endfunction

  task automatic clear_in();
    req_valid = 0; req_hit = 0; req_way = '0; fill_valid = 0; fill_way = '0;
  endtask

  // all tasks start and end at a negedge
  task automatic op_access(bit do_hit, int hway, bit do_fill, int fway,
                           logic [IDX_W-1:0] ix);
    req_valid = do_hit; req_hit = 1; req_way = WAY_W'(hway);
    fill_valid = do_fill; fill_way = WAY_W'(fway); set_idx = ix;
    @(negedge clk);
    clear_in();
    if (do_hit)  model[hway][way_idx(ix, hway)] = 0;
    if (do_fill) model[fway][way_idx(ix, fway)] = 2;
    check(ready === 1'b1, "R10 ready after hit/fill", int'(ready), 1);
  endtask

  task automatic op_miss(logic [IDX_W-1:0] ix, bit inject, string tag);
    int ev;
    ev = exp_victim(ix);
    req_valid = 1; req_hit = 0; set_idx = ix;
    @(negedge clk);
    clear_in();
    check(ready === 1'b0 && victim_valid === 1'b0, "R6 busy after miss",
          int'({ready, victim_valid}), 0);
    if (inject) begin
      // R7: these must be ignored
      req_valid = 1; req_hit = 1; req_way = WAY_W'(ev);
      fill_valid = 1; fill_way = WAY_W'($urandom % WAYS);
      set_idx = ix ^ IDX_W'($urandom);
    end
    @(negedge clk);
    clear_in();
    set_idx = ix;
    check(victim_valid === 1'b1, "R6 victim_valid", int'(victim_valid), 1);
    check(int'(victim_way) == ev, tag, int'(victim_way), ev);
    @(negedge clk);
    check(ready === 1'b1 && victim_valid === 1'b0, "R6 release",
          int'({ready, victim_valid}), 2);
    age_model(ix);
  endtask

  initial begin
    void'($urandom(32'd7731));
    for (int w = 0; w < WAYS; w++)
      for (int s = 0; s < SETS; s++) model[w][s] = 3;
    rst_n = 0; set_idx = '0;
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready === 1'b1 && victim_valid === 1'b0, "R1 reset outputs",
          int'({ready, victim_valid}), 2);
    op_miss(pack_idx(0, 0, 0, 0), 0, "R1 first victim way 0");

    // R2/R4/R5 directed ageing at index 5
    op_access(1, 0, 0, 0, pack_idx(5, 5, 5, 5));
    op_access(1, 1, 0, 0, pack_idx(5, 5, 5, 5));
    op_access(1, 3, 1, 2, pack_idx(5, 5, 5, 5));
    op_miss(pack_idx(5, 5, 5, 5), 0, "R3 R4 victim is filled way 2");
    op_access(1, 2, 0, 0, pack_idx(5, 5, 5, 5));
    op_miss(pack_idx(5, 5, 5, 5), 0, "R5 aged lowest way 0");
    op_miss(pack_idx(5, 5, 5, 5), 0, "R5 repeat miss way 0");
    op_access(1, 0, 0, 0, pack_idx(5, 5, 5, 5));
    op_miss(pack_idx(5, 5, 5, 5), 0, "R5 next victim way 1");

    // R8: fill wins over hit on the same entry
    op_access(0, 0, 1, 1, pack_idx(9, 9, 9, 9));
    op_access(0, 0, 1, 2, pack_idx(9, 9, 9, 9));
    op_access(0, 0, 1, 3, pack_idx(9, 9, 9, 9));
    op_access(1, 0, 1, 0, pack_idx(9, 9, 9, 9));
    op_miss(pack_idx(9, 9, 9, 9), 0, "R8 fill wins way 0");

    // R9: per-way indices select separate entries
    op_access(1, 0, 0, 0, pack_idx(3, 7, 7, 7));
    op_miss(pack_idx(3, 12, 12, 12), 0, "R9 way0 index 3 protected");
    op_miss(pack_idx(4, 7, 7, 7), 0, "R9 way0 index 4 untouched");

    // R7: traffic during busy is ignored
    op_miss(pack_idx(2, 2, 2, 2), 1, "R7 ignored while busy");
    op_miss(pack_idx(2, 2, 2, 2), 1, "R7 ignored while busy again");

    // random mix over small index range
    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [IDX_W-1:0] ix;
      r  = int'($urandom % 10);
      ix = pack_idx(int'($urandom % 4), int'($urandom % 4),
                    int'($urandom % 4), int'($urandom % 4));
      if (r < 4)      op_access(1, int'($urandom % WAYS), 0, 0, ix);
      else if (r < 6) op_access(0, 0, 1, int'($urandom % WAYS), ix);
      else if (r < 7) op_access(1, int'($urandom % WAYS), 1,
                                int'($urandom % WAYS), ix);
      else            op_miss(ix, r[0], "R4 R5 random miss victim");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule